// File: doc/BRIEF.md
# Neighbour Multiplicity and Coincidence Trigger

This block forms a validation trigger for a detector module from the fast-trigger bits of three adjacent 16-channel modules: the left neighbour, the module itself and the right neighbour. Each of the 48 incoming bits first passes through a per-channel conditioner. The conditioner delays the bit by a programmable number of cycles, set per source module, and widens it to a programmable gate. Triggers that reach this module late over the backplane can therefore be aligned with local ones so that they overlap.

The conditioned bits are masked and then judged in one of several modes. In multiplicity mode the number of masked active channels is compared with a threshold. In coincidence mode every module marked as required must show at least one masked active channel. A third mode pairs the module's own masked triggers with a separately conditioned external fast trigger. The judgement passes through a fixed two-stage pipeline.

The rising edge of the resulting condition launches an output pulse of programmable length. A new pulse is not launched until the condition has dropped and risen again.

Top module: `nbr_trig_combine`

## Requirements
- R1: While the reset input is low, and after reset as long as no channel has been active, `vld_o` is 0.
- R2: Trigger and mask bits [15:0] belong to the left neighbour (module index 0), bits [31:16] to the own module (index 1), and bits [47:32] to the right neighbour (index 2). Bit m of `mod_req_i` and delay field m of `mod_dly_i` refer to module index m.
- R3: In mode 0 (multiplicity), the condition is true when the number of conditioned channels that are both active and enabled in `chan_mask_i` is greater than or equal to `mult_thr_i`. Unmasked channels do not count.
- R4: In mode 1 (coincidence), the condition is true when every module whose `mod_req_i` bit is set has at least one active masked channel. If no module is required, the condition is never true.
- R5: In mode 2, the condition is true when an active masked own-module channel coincides with the conditioned `ext_trig_i`. In mode 3, the condition is never true.
- R6: Each conditioned channel stays high for `gate_len_i` cycles after its last high (delayed) sample. A `gate_len_i` of 0 suppresses every channel.
- R7: Every channel of module m, and `ext_trig_i` together with the own module, is delayed by `mod_dly_i[4m+3:4m]` extra cycles before widening.
- R8: When a one-cycle input is sampled at clock edge t and completes the condition on its own, `vld_o` is first high after edge t+4+D, where D is the delay of its module.
- R9: Each output pulse lasts exactly `out_len_i` cycles. An `out_len_i` of 0 produces no pulse.
- R10: The output fires only on a rising edge of the condition. A condition that is held gives a single pulse, and a new pulse follows once the condition has dropped and risen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| trig_i | input | 48 | Fast-trigger bits of the three modules |
| ext_trig_i | input | 1 | External fast trigger used in mode 2 |
| mode_i | input | 2 | 0 multiplicity, 1 coincidence, 2 own-with-external, 3 off |
| chan_mask_i | input | 48 | Per-channel participation mask |
| mod_req_i | input | 3 | Modules required in coincidence mode |
| mult_thr_i | input | 6 | Multiplicity threshold |
| gate_len_i | input | 8 | Input widening length in cycles |
| mod_dly_i | input | 12 | Per-module input delay, 4 bits per module |
| out_len_i | input | 8 | Output pulse length in cycles |
| vld_o | output | 1 | Stretched validation trigger |

## Verification
The embedded properties check these behaviours on every cycle:
- a widened channel only starts from a delayed sample and ends only after its count has run down;
- each module's count stays within its channel total and agrees with its any-active flag;
- mode 3, and coincidence with no required module, never raise the condition;
- an output pulse begins only on a fresh rising edge of the condition, and a zero length yields nothing.

The arithmetic meaning of the modes can only be shown by the bench's scenarios: threshold boundaries, mask exclusion, module bit ranges and the pairing with the external trigger. The same holds for the overlap created by gate widening and delay alignment, for exact latency and pulse width, and for the single pulse under a held condition.

// File: rtl/ntc_pkg.sv
package ntc_pkg;

  typedef enum logic [1:0] {
    MODE_MULT   = 2'd0,
    MODE_COIN   = 2'd1,
    MODE_OWNEXT = 2'd2,
    MODE_OFF    = 2'd3
  } ntc_mode_e;

endpackage

// File: rtl/ntc_trig_cond.sv
module ntc_trig_cond #(
  parameter int DLY_W  = 4,
  parameter int GATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic [DLY_W-1:0]  dly_i,
  input  logic [GATE_W-1:0] gate_i,
  output logic              trig_o
);

  localparam int DEPTH = 1 << DLY_W;

  logic [DEPTH-1:0]  sr_q, sr_d;
  logic [GATE_W-1:0] cnt_q, cnt_d;
  logic              tap;
  logic              cnt_en;

  always_comb begin
    sr_d   = {sr_q[DEPTH-2:0], trig_i};
    tap    = sr_q[dly_i];
    cnt_en = tap || (cnt_q != '0);
    if (tap) cnt_d = gate_i;
    else     cnt_d = cnt_q - GATE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign trig_o = (cnt_q != '0);

  // R6
  widen_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_o) |-> $past(tap));

  // R6
  widen_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trig_o) |-> ($past(cnt_q) == GATE_W'(1) && !$past(tap)));

endmodule

// File: rtl/ntc_mod_eval.sv
module ntc_mod_eval #(
  parameter int CH    = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CH-1:0]    bits_i,
  input  logic [CH-1:0]    mask_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             any_o
);

  logic [CH-1:0]    masked;
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             any_d, any_q;

  always_comb begin
    masked = bits_i & mask_i;
    cnt_d  = '0;
    for (int i = 0; i < CH; i++) begin
      cnt_d = cnt_d + CNT_W'(masked[i]);
    end
    any_d = |masked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      any_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      any_q <= any_d;
    end
  end

  assign cnt_o = cnt_q;
  assign any_o = any_q;

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(CH));

  // R4
  any_cnt_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_q == (cnt_q != '0));

endmodule

// File: rtl/ntc_decide.sv
module ntc_decide
  import ntc_pkg::*;
#(
  parameter int N_MOD   = 3,
  parameter int CNT_W   = 5,
  parameter int TOT_W   = 6,
  parameter int THR_W   = 6,
  parameter int OWN_IDX = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_MOD*CNT_W-1:0] cnt_i,
  input  logic [N_MOD-1:0]       any_i,
  input  logic                   ext_i,
  input  ntc_mode_e              mode_i,
  input  logic [THR_W-1:0]       thr_i,
  input  logic [N_MOD-1:0]       req_i,
  output logic                   cond_o
);

  localparam int CMP_W = ((TOT_W > THR_W) ? TOT_W : THR_W) + 1;

  logic [TOT_W-1:0] sum;
  logic             mult_hit, coin_hit, ox_hit;
  logic             cond_d, cond_q;

  always_comb begin
    sum = '0;
    for (int m = 0; m < N_MOD; m++) begin
      sum = sum + TOT_W'(cnt_i[m*CNT_W +: CNT_W]);
    end
    mult_hit = CMP_W'(sum) >= CMP_W'(thr_i);
    coin_hit = (req_i != '0) && ((any_i | ~req_i) == '1);
    ox_hit   = any_i[OWN_IDX] & ext_i;
    case (mode_i)
      MODE_MULT:   cond_d = mult_hit;
      MODE_COIN:   cond_d = coin_hit;
      MODE_OWNEXT: cond_d = ox_hit;
      default:     cond_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= 1'b0;
    else        cond_q <= cond_d;
  end

  assign cond_o = cond_q;

  // R5
  mode_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_i) == MODE_OFF) |-> !cond_o);

  // R4
  coin_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_i) == MODE_COIN && $past(req_i) == '0) |-> !cond_o);

endmodule

// File: rtl/ntc_out_stretch.sv
module ntc_out_stretch #(
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cond_i,
  input  logic [OUT_W-1:0] len_i,
  output logic             pulse_o
);

  logic             prev_q;
  logic             rise;
  logic [OUT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    rise   = cond_i & ~prev_q;
    cnt_en = rise || (cnt_q != '0);
    if (rise) cnt_d = len_i;
    else      cnt_d = cnt_q - OUT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cond_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pulse_o = (cnt_q != '0);

  // R10
  rise_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> ($past(cond_i) && !$past(cond_i, 2)));

  // R9
  len_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(len_i) == '0 && !$past(pulse_o)) |-> !pulse_o);

endmodule

// File: rtl/nbr_trig_combine.sv
module nbr_trig_combine
  import ntc_pkg::*;
#(
  parameter int CH_PER_MOD = 16,
  parameter int N_MOD      = 3,
  parameter int THR_W      = 6,
  parameter int GATE_W     = 8,
  parameter int DLY_W      = 4,
  parameter int OUT_W      = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_MOD*CH_PER_MOD-1:0] trig_i,
  input  logic                   ext_trig_i,
  input  logic [1:0]             mode_i,
  input  logic [N_MOD*CH_PER_MOD-1:0] chan_mask_i,
  input  logic [N_MOD-1:0]       mod_req_i,
  input  logic [THR_W-1:0]       mult_thr_i,
  input  logic [GATE_W-1:0]      gate_len_i,
  input  logic [N_MOD*DLY_W-1:0] mod_dly_i,
  input  logic [OUT_W-1:0]       out_len_i,
  output logic                   vld_o
);

  localparam int TOT_CH  = N_MOD * CH_PER_MOD;
  localparam int CNT_W   = $clog2(CH_PER_MOD + 1);
  localparam int TOT_W   = $clog2(TOT_CH + 1);
  localparam int OWN_IDX = N_MOD / 2;

  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [TOT_CH-1:0]      wide;
  logic                   ext_wide;
  logic                   ext_s1_q;
  logic [N_MOD*CNT_W-1:0] cnt_all;
  logic [N_MOD-1:0]       any_all;
  logic                   cond;

  for (genvar c = 0; c < TOT_CH; c++) begin : g_chan
    ntc_trig_cond #(.DLY_W(DLY_W), .GATE_W(GATE_W)) u_cond (
      .clk    (clk),
      .rst_n  (rst_sync_q),
      .trig_i (trig_i[c]),
      .dly_i  (mod_dly_i[(c / CH_PER_MOD)*DLY_W +: DLY_W]),
      .gate_i (gate_len_i),
      .trig_o (wide[c])
    );
  end

  ntc_trig_cond #(.DLY_W(DLY_W), .GATE_W(GATE_W)) u_ext_cond (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .trig_i (ext_trig_i),
    .dly_i  (mod_dly_i[OWN_IDX*DLY_W +: DLY_W]),
    .gate_i (gate_len_i),
    .trig_o (ext_wide)
  );

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) ext_s1_q <= 1'b0;
    else             ext_s1_q <= ext_wide;
  end

  for (genvar m = 0; m < N_MOD; m++) begin : g_mod
    ntc_mod_eval #(.CH(CH_PER_MOD), .CNT_W(CNT_W)) u_eval (
      .clk    (clk),
      .rst_n  (rst_sync_q),
      .bits_i (wide[m*CH_PER_MOD +: CH_PER_MOD]),
      .mask_i (chan_mask_i[m*CH_PER_MOD +: CH_PER_MOD]),
      .cnt_o  (cnt_all[m*CNT_W +: CNT_W]),
      .any_o  (any_all[m])
    );
  end

  ntc_decide #(
    .N_MOD(N_MOD), .CNT_W(CNT_W), .TOT_W(TOT_W),
    .THR_W(THR_W), .OWN_IDX(OWN_IDX)
  ) u_decide (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .cnt_i  (cnt_all),
    .any_i  (any_all),
    .ext_i  (ext_s1_q),
    .mode_i (ntc_mode_e'(mode_i)),
    .thr_i  (mult_thr_i),
    .req_i  (mod_req_i),
    .cond_o (cond)
  );

  ntc_out_stretch #(.OUT_W(OUT_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .cond_i  (cond),
    .len_i   (out_len_i),
    .pulse_o (vld_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_sync_q |-> !vld_o);

endmodule

// File: tb/nbr_trig_combine_test.sv
module nbr_trig_combine_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [47:0] trig;
  logic        ext;
  logic [1:0]  mode;
  logic [47:0] mask;
  logic [2:0]  req;
  logic [5:0]  thr;
  logic [7:0]  gate;
  logic [11:0] dly;
  logic [7:0]  olen;
  logic        vld;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  nbr_trig_combine uut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .ext_trig_i(ext),
    .mode_i(mode), .chan_mask_i(mask), .mod_req_i(req),
    .mult_thr_i(thr), .gate_len_i(gate), .mod_dly_i(dly),
    .out_len_i(olen), .vld_o(vld)
  );

  typedef struct packed {
    logic [1:0]  vmode;
    logic [47:0] vmask;
    logic [2:0]  vreq;
    logic [5:0]  vthr;
    logic [47:0] vpat;
    logic        vext;
    logic        vexp;
  } vec_t;

  localparam logic [47:0] ALL = 48'hFFFF_FFFF_FFFF;
  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{2'd0, ALL,             3'b000, 6'd3,  48'h0000_0000_0007, 1'b0, 1'b1}, // R3
    '{2'd0, ALL,             3'b000, 6'd4,  48'h0000_0000_0007, 1'b0, 1'b0}, // R3
    '{2'd0, 48'h0000_FFFF_0000, 3'b000, 6'd2, 48'h0000_0001_0003, 1'b0, 1'b0}, // R3 mask
    '{2'd0, 48'h0000_FFFF_0000, 3'b000, 6'd1, 48'h0000_0001_0003, 1'b0, 1'b1}, // R3
    '{2'd0, ALL,             3'b000, 6'd48, ALL,                1'b0, 1'b1}, // R3
    '{2'd0, ALL,             3'b000, 6'd48, 48'h7FFF_FFFF_FFFF, 1'b0, 1'b0}, // R3
    '{2'd1, ALL,             3'b111, 6'd1,  48'h0001_0001_0001, 1'b0, 1'b1}, // R4
    '{2'd1, ALL,             3'b111, 6'd1,  48'h0000_0001_0001, 1'b0, 1'b0}, // R4
    '{2'd1, ALL,             3'b101, 6'd1,  48'h0100_0000_0020, 1'b0, 1'b1}, // R4
    '{2'd1, ALL,             3'b000, 6'd1,  ALL,                1'b0, 1'b0}, // R4
    '{2'd1, 48'h7FFF_FFFF_FFFF, 3'b111, 6'd1, 48'h8000_0001_0001, 1'b0, 1'b0}, // R2
    '{2'd1, ALL,             3'b010, 6'd1,  48'h0000_0000_8000, 1'b0, 1'b0}, // R2
    '{2'd1, ALL,             3'b010, 6'd1,  48'h0000_0001_0000, 1'b0, 1'b1}, // R2
    '{2'd1, ALL,             3'b100, 6'd1,  48'h0001_0000_0000, 1'b0, 1'b1}, // R2
    '{2'd2, ALL,             3'b000, 6'd1,  48'h0000_0010_0000, 1'b1, 1'b1}, // R5
    '{2'd2, ALL,             3'b000, 6'd1,  48'h0000_0010_0000, 1'b0, 1'b0}, // R5
    '{2'd2, ALL,             3'b000, 6'd1,  48'h0000_0000_0008, 1'b1, 1'b0}, // R5
    '{2'd3, ALL,             3'b111, 6'd1,  ALL,                1'b1, 1'b0}  // R5
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drives pattern pa (with ext ea) for one cycle sampled at edge t, and
  // optionally pb at edge t+gap; observes vld for 48 cycles afterwards.
  task automatic run_pulses(input logic [47:0] pa, input logic ea,
                            input logic [47:0] pb, input int gap,
                            output int first_k, output int width, output int rises);
    logic prev;
    prev = 1'b0; first_k = -1; width = 0; rises = 0;
    @(negedge clk); trig = pa; ext = ea;
    @(posedge clk);
    @(negedge clk); trig = '0; ext = 1'b0;
    for (int k = 1; k <= 48; k++) begin
      if (gap > 0 && k == gap) trig = pb;
      @(posedge clk);
      @(negedge clk);
      if (gap > 0 && k == gap) trig = '0;
      if (vld && !prev) begin
        rises++;
        if (first_k < 0) first_k = k;
      end
      if (vld) width++;
      prev = vld;
    end
  endtask

  task automatic hold_count(input logic [47:0] pat, input int n, output int rises);
    logic prev;
    prev = 1'b0; rises = 0;
    @(negedge clk); trig = pat;
    for (int k = 0; k < n + 20; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == n - 1) trig = '0;
      if (vld && !prev) rises++;
      prev = vld;
    end
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int fk, w, r;
    rst_n = 1'b0;
    trig = '0; ext = 1'b0; mode = 2'd0; mask = ALL; req = 3'b000;
    thr = 6'd3; gate = 8'd1; dly = '0; olen = 8'd3;
    repeat (4) @(negedge clk);
    check(vld == 1'b0, "R1 vld in reset", vld, 0);
    rst_n = 1'b1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check(vld == 1'b0, "R1 vld idle after reset", vld, 0);
    end

    // Vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mode = VEC[i].vmode; mask = VEC[i].vmask; req = VEC[i].vreq; thr = VEC[i].vthr;
      run_pulses(VEC[i].vpat, VEC[i].vext, '0, 0, fk, w, r);
      check(r == int'(VEC[i].vexp), $sformatf("R3/R4/R5 vector %0d fire", i), r, VEC[i].vexp);
      if (VEC[i].vexp) begin
        check(fk == 4, $sformatf("R8 vector %0d latency", i), fk, 4);
        check(w == 3, $sformatf("R9 vector %0d width", i), w, 3);
      end
    end

    // R6: gate widening creates overlap
    @(negedge clk); mode = 2'd1; mask = ALL; req = 3'b101; gate = 8'd4;
    run_pulses(48'h0000_0000_0001, 1'b0, 48'h0001_0000_0000, 3, fk, w, r);
    check(r == 1, "R6 gate 4 overlap fires", r, 1);
    check(fk == 7, "R6 gate 4 overlap latency", fk, 7);
    @(negedge clk); gate = 8'd2;
    run_pulses(48'h0000_0000_0001, 1'b0, 48'h0001_0000_0000, 3, fk, w, r);
    check(r == 0, "R6 gate 2 no overlap", r, 0);

    // R6: gate 0 suppresses
    @(negedge clk); mode = 2'd0; thr = 6'd1; gate = 8'd0;
    run_pulses(48'h0000_0000_0001, 1'b0, '0, 0, fk, w, r);
    check(r == 0, "R6 gate 0 suppress", r, 0);

    // R7: per-module delay aligns late right-module trigger
    @(negedge clk); mode = 2'd1; req = 3'b101; gate = 8'd1; dly = '0;
    run_pulses(48'h0000_0000_0001, 1'b0, 48'h0001_0000_0000, 5, fk, w, r);
    check(r == 0, "R7 no delay misaligned", r, 0);
    @(negedge clk); dly = {4'd0, 4'd0, 4'd5};
    run_pulses(48'h0000_0000_0001, 1'b0, 48'h0001_0000_0000, 5, fk, w, r);
    check(r == 1, "R7 left delay 5 aligns", r, 1);
    check(fk == 9, "R7 delayed latency", fk, 9);

    // R8: latency with delay 3
    @(negedge clk); mode = 2'd0; thr = 6'd1; dly = {4'd3, 4'd3, 4'd3};
    run_pulses(48'h0000_0001_0000, 1'b0, '0, 0, fk, w, r);
    check(fk == 7, "R8 latency delay 3", fk, 7);

    // R9: output length
    @(negedge clk); dly = '0; olen = 8'd7;
    run_pulses(48'h0000_0001_0000, 1'b0, '0, 0, fk, w, r);
    check(w == 7, "R9 width 7", w, 7);
    @(negedge clk); olen = 8'd0;
    run_pulses(48'h0000_0001_0000, 1'b0, '0, 0, fk, w, r);
    check(r == 0, "R9 length 0 no pulse", r, 0);

    // R10: held condition fires once, re-fires after drop
    @(negedge clk); olen = 8'd3;
    hold_count(48'h0000_0000_0010, 30, r);
    check(r == 1, "R10 held single pulse", r, 1);
    hold_count(48'h0000_0000_0010, 30, r);
    check(r == 1, "R10 re-fire after drop", r, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule